// File: doc/BRIEF.md
# Register-to-Peripheral-Bus Bridge

This block is a slave on a 64-bit register bus. It turns a single register write into one transfer on a simple downstream peripheral bus, then reports the outcome through a status word that software polls. A write to the command register carries two things at once. The upper half is a command word: direction, transfer size and a 24-bit target address. The lower half is the write data. If the bridge is idle, it raises its downstream request and holds the transfer fields steady until the responder acknowledges.

A read of the status register returns the status word in the upper half and the read data in the lower half. The status word carries a busy flag and a read-valid flag. It also carries three separate error fields, one for each downstream error source: the bus fabric, a hub-level link and a port-level link. Errors accumulate and stay latched until software writes zero to the status register. A command that arrives while a transfer is in flight is dropped and recorded in a sticky overrun flag. A third register holds a snapshot of the status word taken at the last completion, so software can see it after the live flags have been cleared.

Top module: `obr_bridge`

## Requirements
- R1: After reset, the status word, the read data, the completion snapshot and `bus_req` are all zero.
- R2: A write at offset 0 while idle launches a transfer, and `bus_req` is high from the next cycle. Word bit 63 drives `bus_we` (1 = write). Bits 62:61 drive `bus_size` (00 = 8-bit, 01 = 16-bit, 11 = 32-bit). Bits 55:32 drive `bus_addr` and bits 31:0 drive `bus_wdata`. In the status word, busy (bit 16) becomes 1 and read-valid (bit 17) becomes 0.
- R3: `bus_req` and all transfer fields stay unchanged until a cycle in which `bus_ack` is high.
- R4: On an error-free acknowledge of a read, busy clears and read-valid sets in the same cycle, and the data half of the status register holds `bus_rdata`. Busy and read-valid are never both set.
- R5: On an error-free acknowledge of a write, busy clears, read-valid stays 0 and the data half reads zero.
- R6: On an acknowledge with any non-zero error input, the three codes are placed in the status word as follows: `err_bus` bits 5:0 go to status bits 27 and 24:20 (bit 5 to 27), `err_hub` to bits 15:10, and `err_port` to bits 7:2. Busy clears in that cycle, read-valid stays 0 and the data half reads all ones.
- R7: Error bits are sticky. Later completions OR new codes into them, and a later error-free read still sets read-valid and returns its data.
- R8: A write of zero at offset 1 clears all error bits and the overrun flag (bit 0). A non-zero write at offset 1 changes nothing.
- R9: A write at offset 0 while busy does not alter the transfer in flight and sets overrun (status bit 0), which stays set until cleared as in R8.
- R10: Offset 2 reads the status word as it stood right after the last completion in the upper half and zero in the lower half. R8 does not clear it.
- R11: Offsets 0 and 3 read zero, and writes to offsets 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access strobe, one cycle per write |
| reg_write | input | 1 | 1 = write access |
| reg_offset | input | 2 | Register offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data of the register at `reg_offset` (combinational) |
| bus_req | output | 1 | Downstream transfer request |
| bus_we | output | 1 | Downstream direction, 1 = write |
| bus_size | output | 2 | Downstream transfer size code |
| bus_addr | output | 24 | Downstream address |
| bus_wdata | output | 32 | Downstream write data |
| bus_ack | input | 1 | Downstream acknowledge, sampled while `bus_req` is high |
| bus_rdata | input | 32 | Downstream read data, valid with `bus_ack` |
| err_bus | input | 6 | Fabric error code, valid with `bus_ack` |
| err_hub | input | 6 | Hub link error code, valid with `bus_ack` |
| err_port | input | 6 | Port link error code, valid with `bus_ack` |

## Verification
The bench checks the following cases, each chosen to expose a specific fault:
- An acknowledge in the very first cycle of a transfer. A design that delays busy-clear from the completion flags would show both busy and read-valid set, or neither.
- A read that fails. A design that leaks `bus_rdata` or sets read-valid in that case fails the check.
- A second command issued while busy. A design that accepts it would move `bus_addr` mid-transfer.
- A non-zero status write and a second error on top of the first. A design that clears on any write, or overwrites instead of accumulating, loses error bits.
- Every error code placed on all six bits of its field. A shifted bit mapping in any of the three fields then shows up.

// File: rtl/obr_pkg.sv
package obr_pkg;
    localparam int ADDR_W  = 24;
    localparam int DATA_W  = 32;
    localparam int ERRF_W  = 6;
    localparam int REG_W   = 2 * DATA_W;
    localparam int SIZE_W  = 2;

    localparam int B_OVR   = 0;
    localparam int B_BUSY  = 16;
    localparam int B_RVAL  = 17;
    localparam int B_PORT  = 2;
    localparam int B_HUB   = 10;
    localparam int B_FAB   = 20;
    localparam int B_FABHI = 27;

    localparam logic [1:0] OFS_CMD  = 2'd0;
    localparam logic [1:0] OFS_STAT = 2'd1;
    localparam logic [1:0] OFS_SNAP = 2'd2;

    typedef struct packed {
        logic              we;
        logic [SIZE_W-1:0] size;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } cmd_t;

    typedef struct packed {
        logic              busy;
        cmd_t              cmd;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
        logic [ERRF_W-1:0] e_fab;
        logic [ERRF_W-1:0] e_hub;
        logic [ERRF_W-1:0] e_port;
        logic              ovr;
        logic [DATA_W-1:0] snap;
    } state_t;

    function automatic logic [DATA_W-1:0] pack_status(
        input logic busy, input logic rvalid,
        input logic [ERRF_W-1:0] ef, input logic [ERRF_W-1:0] eh,
        input logic [ERRF_W-1:0] ep, input logic ovr);
        logic [DATA_W-1:0] w;
        w = '0;
        w[B_BUSY] = busy;
        w[B_RVAL] = rvalid;
        w[B_OVR]  = ovr;
        w[B_FABHI] = ef[ERRF_W-1];
        w[B_FAB +: ERRF_W-1] = ef[ERRF_W-2:0];
        w[B_HUB +: ERRF_W]   = eh;
        w[B_PORT +: ERRF_W]  = ep;
        return w;
    endfunction
endpackage

// File: rtl/obr_cmd_decode.sv
module obr_cmd_decode
    import obr_pkg::*;
(
    input  logic [REG_W-1:0] word,
    output cmd_t             cmd
);
    localparam int CW_TOP = REG_W - 1;

    always_comb begin
        cmd.we    = word[CW_TOP];
        cmd.size  = word[CW_TOP-1 -: SIZE_W];
        cmd.addr  = word[DATA_W +: ADDR_W];
        cmd.wdata = word[DATA_W-1:0];
    end
endmodule

// File: rtl/obr_stat_pack.sv
module obr_stat_pack
    import obr_pkg::*;
(
    input  logic              busy,
    input  logic              rvalid,
    input  logic [ERRF_W-1:0] e_fab,
    input  logic [ERRF_W-1:0] e_hub,
    input  logic [ERRF_W-1:0] e_port,
    input  logic              ovr,
    output logic [DATA_W-1:0] stat
);
    always_comb stat = pack_status(busy, rvalid, e_fab, e_hub, e_port, ovr);
endmodule

// File: rtl/obr_bridge.sv
module obr_bridge
    import obr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [1:0]        reg_offset,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [SIZE_W-1:0] bus_size,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic [ERRF_W-1:0] err_bus,
    input  logic [ERRF_W-1:0] err_hub,
    input  logic [ERRF_W-1:0] err_port
);
    state_t            s_d, s_q;
    cmd_t              cmd_in;
    logic [DATA_W-1:0] stat_w;
    logic              cmd_wr, stat_wr, stat_clr, any_err;
    logic [ERRF_W-1:0] nf, nh, np;

    obr_cmd_decode i_dec (.word(reg_wdata), .cmd(cmd_in));

    obr_stat_pack i_pack (
        .busy(s_q.busy), .rvalid(s_q.rvalid), .e_fab(s_q.e_fab),
        .e_hub(s_q.e_hub), .e_port(s_q.e_port), .ovr(s_q.ovr), .stat(stat_w)
    );

    always_comb begin
        cmd_wr   = reg_valid && reg_write && (reg_offset == OFS_CMD);
        stat_wr  = reg_valid && reg_write && (reg_offset == OFS_STAT);
        stat_clr = stat_wr && (reg_wdata == '0);
        any_err  = |{err_bus, err_hub, err_port};
        nf = '0;
        nh = '0;
        np = '0;

        s_d = s_q;
        if (stat_clr) begin
            s_d.e_fab  = '0;
            s_d.e_hub  = '0;
            s_d.e_port = '0;
            s_d.ovr    = 1'b0;
        end

        if (s_q.busy) begin
            if (cmd_wr) s_d.ovr = 1'b1;
            if (bus_ack) begin
                s_d.busy   = 1'b0;
                nf = s_d.e_fab  | err_bus;
                nh = s_d.e_hub  | err_hub;
                np = s_d.e_port | err_port;
                s_d.e_fab  = nf;
                s_d.e_hub  = nh;
                s_d.e_port = np;
                if (any_err) begin
                    s_d.rvalid = 1'b0;
                    s_d.rdata  = '1;
                end else if (s_q.cmd.we) begin
                    s_d.rvalid = 1'b0;
                    s_d.rdata  = '0;
                end else begin
                    s_d.rvalid = 1'b1;
                    s_d.rdata  = bus_rdata;
                end
                s_d.snap = pack_status(1'b0, s_d.rvalid, nf, nh, np, s_d.ovr);
            end
        end else if (cmd_wr) begin
            s_d.busy   = 1'b1;
            s_d.cmd    = cmd_in;
            s_d.rvalid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        unique case (reg_offset)
            OFS_STAT: reg_rdata = {stat_w, s_q.rdata};
            OFS_SNAP: reg_rdata = {s_q.snap, {DATA_W{1'b0}}};
            default:  reg_rdata = '0;
        endcase
    end

    assign bus_req   = s_q.busy;
    assign bus_we    = s_q.cmd.we;
    assign bus_size  = s_q.cmd.size;
    assign bus_addr  = s_q.cmd.addr;
    assign bus_wdata = s_q.cmd.wdata;
endmodule

// File: rtl/obr_bridge_chk.sv
module obr_bridge_chk
    import obr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_valid,
    input logic              reg_write,
    input logic [1:0]        reg_offset,
    input logic [REG_W-1:0]  reg_wdata,
    input logic              bus_req,
    input logic              bus_ack,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [ERRF_W-1:0] err_bus,
    input logic [ERRF_W-1:0] err_hub,
    input logic [ERRF_W-1:0] err_port,
    input logic [DATA_W-1:0] stat,
    input logic [DATA_W-1:0] rd_field
);
    localparam logic [DATA_W-1:0] ERR_MASK = 32'h09F0_FCFC;

    logic cmd_wr, clr_wr, done;
    assign cmd_wr = reg_valid && reg_write && reg_offset == OFS_CMD;
    assign clr_wr = reg_valid && reg_write && reg_offset == OFS_STAT && reg_wdata == '0;
    assign done   = bus_req && bus_ack;

    a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat[B_BUSY] && cmd_wr) |=> (bus_req && bus_addr == $past(reg_wdata[DATA_W +: ADDR_W])
                                       && bus_we == $past(reg_wdata[REG_W-1])));
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));
    a_r4_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !stat[B_BUSY]);
    a_r4_busy_rvalid_excl: assert property (@(posedge clk) disable iff (!rst_n)
        stat[B_RVAL] |-> !stat[B_BUSY]);
    a_r6_err_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (|{err_bus, err_hub, err_port})) |=> (!stat[B_RVAL] && rd_field == '1));
    a_r9_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[B_BUSY] && cmd_wr) |=> stat[B_OVR]);
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !done) |=> ((stat & ERR_MASK) == '0 && !stat[B_OVR]));
endmodule

bind obr_bridge obr_bridge_chk i_chk (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_offset(reg_offset), .reg_wdata(reg_wdata), .bus_req(bus_req),
    .bus_ack(bus_ack), .bus_we(bus_we), .bus_addr(bus_addr),
    .err_bus(err_bus), .err_hub(err_hub), .err_port(err_port),
    .stat(stat_w), .rd_field(s_q.rdata)
);

// File: tb/test_obr_bridge.sv
module test_obr_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [1:0]  reg_offset = 2'd0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        bus_req, bus_we;
    logic [1:0]  bus_size;
    logic [23:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic [5:0]  err_bus = '0, err_hub = '0, err_port = '0;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    obr_bridge i_obr_bridge (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] sw(input bit busy, input bit rv, input logic [5:0] ef,
                                       input logic [5:0] eh, input logic [5:0] ep, input bit ov);
        logic [31:0] w = '0;
        w[16] = busy; w[17] = rv; w[0] = ov;
        w[27] = ef[5]; w[24:20] = ef[4:0];
        w[15:10] = eh; w[7:2] = ep;
        return w;
    endfunction

    function automatic logic [63:0] cw(input bit we, input logic [1:0] sz,
                                       input logic [23:0] a, input logic [31:0] d);
        return {we, sz, 5'b0, a, d};
    endfunction

    task automatic reg_wr(input logic [1:0] off, input logic [63:0] d);
        @(negedge clk);
        reg_valid = 1; reg_write = 1; reg_offset = off; reg_wdata = d;
        @(negedge clk);
        reg_valid = 0; reg_write = 0;
    endtask

    task automatic reg_rd(input logic [1:0] off, output logic [63:0] d);
        reg_offset = off;
        #1;
        d = reg_rdata;
    endtask

    task automatic respond(input int dly, input logic [31:0] rd,
                           input logic [5:0] ef, input logic [5:0] eh, input logic [5:0] ep);
        repeat (dly) @(negedge clk);
        bus_ack = 1; bus_rdata = rd; err_bus = ef; err_hub = eh; err_port = ep;
        @(negedge clk);
        bus_ack = 0; err_bus = '0; err_hub = '0; err_port = '0;
    endtask

    task automatic t_reset();
        logic [63:0] d;
        reg_rd(2'd1, d); chk("R1 status", d, 64'h0);
        reg_rd(2'd2, d); chk("R1 snapshot", d, 64'h0);
        chk("R1 bus_req", bus_req, 0);
    endtask

    task automatic t_read_ok();
        logic [63:0] d;
        reg_wr(2'd0, cw(0, 2'b11, 24'h123456, 32'h0));
        chk("R2 req/we/size/addr", {bus_req, bus_we, bus_size, bus_addr}, {1'b1, 1'b0, 2'b11, 24'h123456});
        reg_rd(2'd1, d); chk("R2 busy", d[63:32], sw(1, 0, 0, 0, 0, 0));
        repeat (3) @(negedge clk);
        chk("R3 held", {bus_req, bus_addr}, {1'b1, 24'h123456});
        respond(0, 32'hCAFEF00D, 0, 0, 0);
        reg_rd(2'd1, d); chk("R4 read done", d, {sw(0, 1, 0, 0, 0, 0), 32'hCAFEF00D});
        chk("R4 req low", bus_req, 0);
        reg_rd(2'd2, d); chk("R10 snapshot", d, {sw(0, 1, 0, 0, 0, 0), 32'h0});
    endtask

    task automatic t_write_ok();
        logic [63:0] d;
        reg_wr(2'd0, cw(1, 2'b00, 24'h0000AB, 32'h0000005A));
        chk("R2 write fields", {bus_we, bus_size, bus_wdata}, {1'b1, 2'b00, 32'h5A});
        reg_rd(2'd1, d); chk("R2 launch clears rvalid", d[63:32], sw(1, 0, 0, 0, 0, 0));
        respond(2, 32'h77777777, 0, 0, 0);
        reg_rd(2'd1, d); chk("R5 write done", d, {sw(0, 0, 0, 0, 0, 0), 32'h0});
        reg_wr(2'd0, cw(0, 2'b01, 24'hFFFFFF, 32'h0));
        chk("R2 size16", {bus_size, bus_addr}, {2'b01, 24'hFFFFFF});
        respond(0, 32'h0000BEEF, 0, 0, 0);
        reg_rd(2'd1, d); chk("R4 size16 data", d, {sw(0, 1, 0, 0, 0, 0), 32'h0000BEEF});
    endtask

    task automatic t_errors();
        logic [63:0] d;
        reg_wr(2'd0, cw(0, 2'b11, 24'h000100, 32'h0));
        respond(1, 32'h12345678, 6'b100001, 0, 0);
        reg_rd(2'd1, d); chk("R6 fabric error", d, {sw(0, 0, 6'b100001, 0, 0, 0), 32'hFFFFFFFF});
        reg_wr(2'd0, cw(0, 2'b11, 24'h000200, 32'h0));
        respond(0, 32'h1, 0, 6'b000011, 0);
        reg_rd(2'd1, d); chk("R7 accumulate", d, {sw(0, 0, 6'b100001, 6'b000011, 0, 0), 32'hFFFFFFFF});
        reg_wr(2'd0, cw(0, 2'b11, 24'h000300, 32'h0));
        respond(0, 32'hA5A5A5A5, 0, 0, 0);
        reg_rd(2'd1, d); chk("R7 sticky after ok read", d, {sw(0, 1, 6'b100001, 6'b000011, 0, 0), 32'hA5A5A5A5});
        reg_wr(2'd1, 64'h1);
        reg_rd(2'd1, d); chk("R8 nonzero write ignored", d, {sw(0, 1, 6'b100001, 6'b000011, 0, 0), 32'hA5A5A5A5});
        reg_wr(2'd1, 64'h0);
        reg_rd(2'd1, d); chk("R8 clear", d, {sw(0, 1, 0, 0, 0, 0), 32'hA5A5A5A5});
        reg_rd(2'd2, d); chk("R10 snapshot kept", d, {sw(0, 1, 6'b100001, 6'b000011, 0, 0), 32'h0});
        reg_wr(2'd0, cw(1, 2'b11, 24'h000400, 32'h9));
        respond(0, 32'h0, 6'b011110, 6'b111100, 6'b111111);
        reg_rd(2'd1, d); chk("R6 all fields", d, {sw(0, 0, 6'b011110, 6'b111100, 6'b111111, 0), 32'hFFFFFFFF});
        chk("R6 port bits", d[39:32], 8'hFC);
        reg_wr(2'd1, 64'h0);
    endtask

    task automatic t_overrun();
        logic [63:0] d;
        reg_wr(2'd0, cw(0, 2'b11, 24'h00AAAA, 32'h0));
        reg_wr(2'd0, cw(1, 2'b00, 24'h00BBBB, 32'h5));
        chk("R9 transfer unchanged", {bus_req, bus_we, bus_size, bus_addr}, {1'b1, 1'b0, 2'b11, 24'h00AAAA});
        reg_rd(2'd1, d); chk("R9 overrun set", d[63:32], sw(1, 0, 0, 0, 0, 1));
        respond(0, 32'h00000042, 0, 0, 0);
        reg_rd(2'd1, d); chk("R9 overrun sticky", d, {sw(0, 1, 0, 0, 0, 1), 32'h42});
        reg_wr(2'd1, 64'h0);
        reg_rd(2'd1, d); chk("R8 overrun cleared", d[63:32], sw(0, 1, 0, 0, 0, 0));
    endtask

    task automatic t_offsets();
        logic [63:0] d;
        reg_wr(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        reg_wr(2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R11 no launch", bus_req, 0);
        reg_rd(2'd0, d); chk("R11 offset0 reads zero", d, 64'h0);
        reg_rd(2'd3, d); chk("R11 offset3 reads zero", d, 64'h0);
        reg_rd(2'd1, d); chk("R11 status untouched", d, {sw(0, 1, 0, 0, 0, 0), 32'h42});
        reg_rd(2'd2, d); chk("R11 snapshot untouched", d, {sw(0, 1, 0, 0, 0, 1), 32'h0});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_read_ok();
        t_write_ok();
        t_errors();
        t_overrun();
        t_offsets();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule